// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block ranks and acknowledges interrupts for a serial peripheral and the DMA engine that sits next to it. The serial side has six interrupt types in a fixed order. Each type keeps a pending flag, an in-service flag and an enable flag, and each of its event sources must be armed before it can raise its type. The DMA side has eight sources: four for receive and four for transmit. Each source has its own enable, and the DMA group has a master enable of its own. Both groups use the same ranking logic.

The two groups are linked in a priority chain. The chain input feeds the serial group. The serial group passes the chain to the DMA group. The DMA group drives the chain output. On an acknowledge strobe, only the group that has a live request and an open chain input answers. It marks its best type as in service and returns its own base vector, with bits [3:1] replaced by the type code. That type and every type below it in the same group stay masked until software issues a release command. The release command frees only the most urgent in-service type. The host bus decode is not part of this block: settings arrive as simple register writes.

Top module: `irq_daisy_ctrl`

## Requirements
- R1: `irq_n_o` is low exactly when some type in either group is pending, type-enabled, group-master-enabled and not masked by an in-service flag. It is high after reset.
- R2: A pulse on an armed serial source sets the pending flag of its type. Serial source `s` belongs to type `s / SRC_PER_TYPE`, and its arm bit is bit `s` of register 1. A pulse on an unarmed source has no effect.
- R3: A type with a clear type-enable bit does not request. Nothing in a group requests while that group's master enable is clear. Register 0 holds the serial master enable in bit 0 and the type enables in bits [13:8]. Register 4 holds the same fields for the DMA group, with source enables in bits [15:8].
- R4: On an acknowledge, the group that answers returns its most urgent live type. Type 0 is the most urgent. The vector is `{base[7:4], code[2:0], base[0]}` and is valid, with `vec_oe_o` high, in the single cycle after the strobe. Register 7 holds the serial base in bits [7:0] and the DMA base in bits [15:8].
- R5: Once a type is in service, it and every less urgent type in its group stop requesting. More urgent types in the same group still request.
- R6: An acknowledge while `ie_i` is low is ignored. No vector is returned and no in-service flag is set.
- R7: `ie_o` is low when `ie_i` is low, or when either group has a pending, enabled (type and master) type, or an in-service type. Otherwise `ie_o` is high.
- R8: Writing a one to a bit of register 2 (serial, bits [5:0]) or register 5 (DMA, bits [7:0]) clears that pending flag. Zero bits leave their flags unchanged.
- R9: Writing a one to bit 0 of register 3 (serial) or register 6 (DMA) clears only the most urgent set in-service flag of that group.
- R10: Serial type codes are 0 (receive status) to 5 (device status). DMA codes are 0 to 3 for the receive sources and 4 to 7 for the transmit sources. The serial group ranks above the DMA group in the chain. An acknowledge reaches the DMA group only when the serial group is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register index |
| wr_data_i | input | 16 | Register write data |
| ser_evt_i | input | 12 | Serial source event pulses |
| dma_evt_i | input | 8 | DMA source event pulses |
| inta_i | input | 1 | Acknowledge strobe, one cycle |
| ie_i | input | 1 | Chain enable in |
| ie_o | output | 1 | Chain enable out |
| irq_n_o | output | 1 | Interrupt request, active low |
| vec_o | output | 8 | Returned vector |
| vec_oe_o | output | 1 | Vector drive enable |

## Verification
Each flag in this block is visible at the ports within one cycle. A lost or stray pending flag changes `irq_n_o` and `ie_o` right after the edge that should have set or cleared it. A wrong in-service flag shows up at the next acknowledge: either as a wrong code in `vec_o`, or as a request that stays silent or keeps asserting when it should do the opposite. Release commands are checked one at a time against the expected `irq_n_o` level. This way a release that clears the wrong flag is caught before the next acknowledge.

// File: rtl/irq_daisy_pkg.sv
package irq_daisy_pkg;
  localparam int N_SER   = 6;
  localparam int N_DMA   = 8;
  localparam int CODE_W  = 3;
  localparam int VEC_W   = 8;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SER_CTRL = 3'd0,
    A_SER_ARM  = 3'd1,
    A_SER_CLR  = 3'd2,
    A_SER_REL  = 3'd3,
    A_DMA_CTRL = 3'd4,
    A_DMA_CLR  = 3'd5,
    A_DMA_REL  = 3'd6,
    A_VEC_BASE = 3'd7
  } reg_addr_e;

  function automatic logic [VEC_W-1:0] mk_vec(input logic [VEC_W-1:0] base,
                                              input logic [CODE_W-1:0] code);
    return {base[VEC_W-1:4], code, base[0]};
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_daisy_pkg::*;
#(
  parameter int N_SRC = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              ser_me_o,
  output logic [N_SER-1:0]  ser_en_o,
  output logic [N_SRC-1:0]  ser_arm_o,
  output logic [N_SER-1:0]  ser_clr_o,
  output logic              ser_rel_o,
  output logic              dma_me_o,
  output logic [N_DMA-1:0]  dma_en_o,
  output logic [N_DMA-1:0]  dma_clr_o,
  output logic              dma_rel_o,
  output logic [VEC_W-1:0]  ser_base_o,
  output logic [VEC_W-1:0]  dma_base_o
);
  logic [ADDR_W-1:0] a;
  assign a = wr_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_me_o   <= 1'b0;
      ser_en_o   <= '0;
      ser_arm_o  <= '0;
      dma_me_o   <= 1'b0;
      dma_en_o   <= '0;
      ser_base_o <= '0;
      dma_base_o <= '0;
    end else if (wr_en_i) begin
      case (a)
        A_SER_CTRL: begin
          ser_me_o <= wr_data_i[0];
          ser_en_o <= wr_data_i[8 +: N_SER];
        end
        A_SER_ARM: ser_arm_o <= wr_data_i[N_SRC-1:0];
        A_DMA_CTRL: begin
          dma_me_o <= wr_data_i[0];
          dma_en_o <= wr_data_i[8 +: N_DMA];
        end
        A_VEC_BASE: begin
          ser_base_o <= wr_data_i[VEC_W-1:0];
          dma_base_o <= wr_data_i[DATA_W-1:VEC_W];
        end
        default: ;
      endcase
    end
  end

  assign ser_clr_o = (wr_en_i && a == A_SER_CLR) ? wr_data_i[N_SER-1:0] : '0;
  assign dma_clr_o = (wr_en_i && a == A_DMA_CLR) ? wr_data_i[N_DMA-1:0] : '0;
  assign ser_rel_o = wr_en_i && a == A_SER_REL && wr_data_i[0];
  assign dma_rel_o = wr_en_i && a == A_DMA_REL && wr_data_i[0];
endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate #(
  parameter int N_TYPE = 6,
  parameter int SPT    = 2,
  localparam int N_SRC = N_TYPE * SPT
) (
  input  logic [N_SRC-1:0]  evt_i,
  input  logic [N_SRC-1:0]  arm_i,
  output logic [N_TYPE-1:0] set_o
);
  for (genvar t = 0; t < N_TYPE; t++) begin : g_type
    assign set_o[t] = |(evt_i[t*SPT +: SPT] & arm_i[t*SPT +: SPT]);
  end
endmodule

// File: rtl/irq_prio_group.sv
module irq_prio_group #(
  parameter int N      = 6,
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      set_i,
  input  logic [N-1:0]      clr_i,
  input  logic [N-1:0]      en_i,
  input  logic              me_i,
  input  logic              ie_in_i,
  input  logic              ack_i,
  input  logic              rel_i,
  output logic              req_o,
  output logic              busy_o,
  output logic              take_o,
  output logic [CODE_W-1:0] code_o
);
  logic [N-1:0] pend_q, ius_q, blk, armed, live, sel, ius_low;

  // in-service flag blocks its own type and all less urgent ones
  assign blk[0] = ius_q[0];
  for (genvar i = 1; i < N; i++) begin : g_blk
    assign blk[i] = blk[i-1] | ius_q[i];
  end

  assign armed = pend_q & en_i & {N{me_i}};
  assign live  = armed & ~blk;

  always_comb begin
    sel    = '0;
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (live[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
        code_o = CODE_W'(i);
      end
    end
  end

  assign req_o   = |live;
  assign busy_o  = (|armed) | (|ius_q);
  assign take_o  = ack_i & ie_in_i & req_o;
  assign ius_low = ius_q & (~ius_q + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ius_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | set_i;
      ius_q  <= (ius_q & ~(rel_i ? ius_low : '0)) | (take_o ? sel : '0);
    end
  end
endmodule

// File: rtl/irq_daisy_ctrl.sv
module irq_daisy_ctrl
  import irq_daisy_pkg::*;
#(
  parameter int SRC_PER_TYPE = 2,
  localparam int N_SRC = N_SER * SRC_PER_TYPE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [N_SRC-1:0]  ser_evt_i,
  input  logic [N_DMA-1:0]  dma_evt_i,
  input  logic              inta_i,
  input  logic              ie_i,
  output logic              ie_o,
  output logic              irq_n_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_oe_o
);
  logic              ser_me, dma_me, ser_rel, dma_rel;
  logic [N_SER-1:0]  ser_en, ser_clr, ser_set;
  logic [N_DMA-1:0]  dma_en, dma_clr;
  logic [N_SRC-1:0]  ser_arm;
  logic [VEC_W-1:0]  ser_base, dma_base;
  logic              ser_req, ser_busy, ser_take;
  logic              dma_req, dma_busy, dma_take;
  logic [CODE_W-1:0] ser_code, dma_code;
  logic              ie_mid;

  irq_cfg_regs #(.N_SRC(N_SRC)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ser_me_o(ser_me), .ser_en_o(ser_en), .ser_arm_o(ser_arm),
    .ser_clr_o(ser_clr), .ser_rel_o(ser_rel),
    .dma_me_o(dma_me), .dma_en_o(dma_en), .dma_clr_o(dma_clr),
    .dma_rel_o(dma_rel), .ser_base_o(ser_base), .dma_base_o(dma_base)
  );

  irq_src_gate #(.N_TYPE(N_SER), .SPT(SRC_PER_TYPE)) i_gate (
    .evt_i(ser_evt_i), .arm_i(ser_arm), .set_o(ser_set)
  );

  irq_prio_group #(.N(N_SER), .CODE_W(CODE_W)) i_ser (
    .clk_i, .rst_ni, .set_i(ser_set), .clr_i(ser_clr), .en_i(ser_en),
    .me_i(ser_me), .ie_in_i(ie_i), .ack_i(inta_i), .rel_i(ser_rel),
    .req_o(ser_req), .busy_o(ser_busy), .take_o(ser_take), .code_o(ser_code)
  );

  assign ie_mid = ie_i & ~ser_busy;

  irq_prio_group #(.N(N_DMA), .CODE_W(CODE_W)) i_dma (
    .clk_i, .rst_ni, .set_i(dma_evt_i), .clr_i(dma_clr), .en_i(dma_en),
    .me_i(dma_me), .ie_in_i(ie_mid), .ack_i(inta_i), .rel_i(dma_rel),
    .req_o(dma_req), .busy_o(dma_busy), .take_o(dma_take), .code_o(dma_code)
  );

  assign ie_o    = ie_mid & ~dma_busy;
  assign irq_n_o = ~(ser_req | dma_req);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o    <= '0;
      vec_oe_o <= 1'b0;
    end else begin
      vec_oe_o <= ser_take | dma_take;
      if (ser_take)      vec_o <= mk_vec(ser_base, ser_code);
      else if (dma_take) vec_o <= mk_vec(dma_base, dma_code);
    end
  end
endmodule

// File: rtl/irq_daisy_chk.sv
module irq_daisy_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic inta_i,
  input logic ie_i,
  input logic ie_o,
  input logic irq_n_o,
  input logic vec_oe_o
);
  AST_VEC_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> $past(inta_i)); // R4
  AST_VEC_NEEDS_IEI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> $past(ie_i)); // R6
  AST_VEC_NEEDS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_oe_o |-> $past(!irq_n_o)); // R1
  AST_IEO_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_i |-> !ie_o); // R7
  AST_IRQ_HOLDS_IEO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_n_o |-> !ie_o); // R7
endmodule

bind irq_daisy_ctrl irq_daisy_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .inta_i(inta_i), .ie_i(ie_i),
  .ie_o(ie_o), .irq_n_o(irq_n_o), .vec_oe_o(vec_oe_o)
);

// File: tb/test_irq_daisy_ctrl.sv
module test_irq_daisy_ctrl;
  logic        clk = 0, rst_ni = 0;
  logic        wr_en = 0, inta = 0, ie_in = 1;
  logic [2:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [11:0] ser_evt = 0;
  logic [7:0]  dma_evt = 0;
  logic        ie_out, irq_n, vec_oe;
  logic [7:0]  vec;
  int          n_run = 0, n_fail = 0;
  logic [7:0]  exp_q[$];
  bit          done = 0;

  always #10 clk = ~clk;

  irq_daisy_ctrl i_irq_daisy_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ser_evt_i(ser_evt), .dma_evt_i(dma_evt),
    .inta_i(inta), .ie_i(ie_in), .ie_o(ie_out), .irq_n_o(irq_n),
    .vec_o(vec), .vec_oe_o(vec_oe)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic sev(int s);
    @(negedge clk); ser_evt = 12'(1) << s;
    @(negedge clk); ser_evt = 0;
  endtask

  task automatic dev(int s);
    @(negedge clk); dma_evt = 8'(1) << s;
    @(negedge clk); dma_evt = 0;
  endtask

  // driver: pushes expected vector (if any) and pulses acknowledge
  task automatic ack(bit expect_vec, logic [7:0] v);
    if (expect_vec) exp_q.push_back(v);
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0;
    @(negedge clk);
    if (expect_vec) chk("R4 vector consumed", 8'(exp_q.size()), 8'd0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && vec_oe) begin
      if (exp_q.size() == 0) chk("R6 unexpected vector", vec, 8'hxx);
      else chk("R4/R10 vector", vec, exp_q.pop_front());
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset irq_n", irq_n, 1);
    chk("R7 reset ie_o", ie_out, 1);
    chk("R4 reset vec_oe", vec_oe, 0);
    rst_ni = 1;
    @(negedge clk);
    wr(3'd7, 16'h50A1);
    wr(3'd0, 16'h3F01);
    wr(3'd1, 16'h0FFD);           // source 1 unarmed
    wr(3'd4, 16'hFF01);
    sev(1);
    chk("R2 unarmed ignored irq", irq_n, 1);
    chk("R2 unarmed ignored ie", ie_out, 1);
    sev(6);                        // type 3
    chk("R2 armed sets pending", irq_n, 0);
    chk("R7 busy drops ie_o", ie_out, 0);
    wr(3'd0, 16'h3701);
    chk("R3 type enable gates", irq_n, 1);
    chk("R7 disabled pending ie_o", ie_out, 1);
    wr(3'd0, 16'h3F00);
    chk("R3 master enable gates", irq_n, 1);
    wr(3'd0, 16'h3F01);
    sev(2);                        // type 1
    ie_in = 0;
    chk("R7 ie_i low", ie_out, 0);
    ack(0, 8'h00);
    chk("R6 ack ignored keeps request", irq_n, 0);
    ie_in = 1;
    ack(1, 8'hA3);                 // code 1
    chk("R5 in-service masks lower", irq_n, 1);
    sev(0);                        // type 0
    chk("R5 more urgent still requests", irq_n, 0);
    ack(1, 8'hA1);                 // code 0
    chk("R5 all masked", irq_n, 1);
    wr(3'd3, 16'h0001);
    chk("R9 release frees only type 0", irq_n, 0);
    wr(3'd2, 16'h0001);
    chk("R8 w1c clears pending", irq_n, 1);
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0001);
    chk("R9 second release frees type 1", irq_n, 0);
    wr(3'd2, 16'h0002);
    chk("R8 type 3 still pending", irq_n, 0);
    ack(1, 8'hA7);                 // code 3
    wr(3'd2, 16'h0008);
    wr(3'd3, 16'h0001);
    chk("R1 idle irq", irq_n, 1);
    chk("R7 idle ie_o", ie_out, 1);
    // chain order with DMA
    dev(5);
    sev(8);                        // type 4
    ack(1, 8'hA9);                 // serial answers first
    chk("R10 DMA still requesting", irq_n, 0);
    ack(0, 8'h00);                 // serial busy blocks DMA
    wr(3'd2, 16'h0010);
    wr(3'd3, 16'h0001);
    ack(1, 8'h5A);                 // DMA code 5
    chk("R5 DMA in service", irq_n, 1);
    wr(3'd5, 16'h0020);
    wr(3'd6, 16'h0001);
    chk("R9 DMA released ie_o", ie_out, 1);
    dev(0);
    wr(3'd4, 16'hFF00);
    chk("R3 DMA master gates", irq_n, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule